// File: doc/BRIEF.md
# Sliding-Window Access Locality Meter

This block measures how concentrated a memory access profile is. It reads a histogram of per-address access counts, one count per accepted cycle, in ascending address order. Over the profile it tracks two values. The first is the largest sum of counts found in any run of `WIN` adjacent addresses. The second is the sum of all counts. Software divides the first by the second to get a locality ratio, and uses that ratio to choose a bank size when it partitions a memory.

A profile opens with a start strobe and closes with an end strobe. One cycle after the end strobe the block raises a done pulse, and the peak and total values appear on its result ports. Those values stay on the ports until the next end strobe. The window length `WIN` is fixed at compile time and may be any power of two from 32 to 512. The block computes no ratio and does not build the histogram.

Top module: `swl_locality_meter`

## Requirements
- R1: After reset, `done_o` is 0 and both `peak_o` and `total_o` are 0.
- R2: `total_o` gives the sum of every count accepted since the most recent start strobe. A count is accepted when `cnt_valid_i` is 1 and `prof_start_i` is 0.
- R3: For a profile of N ≥ `WIN` accepted counts c0..cN-1, `peak_o` gives the maximum, over every start position i from 0 to N-`WIN`, of the sum c_i + ... + c_(i+`WIN`-1).
- R4: For a profile of fewer than `WIN` accepted counts, including an empty profile, `peak_o` equals `total_o`.
- R5: `done_o` is 1 for exactly the one cycle after each cycle in which `prof_end_i` is 1. In every other cycle it is 0. `peak_o` and `total_o` change only in the cycle in which `done_o` rises, and keep their values until the next done.
- R6: A start strobe throws away all counts accepted before it. A count offered with `cnt_valid_i` in the same cycle as the start strobe is dropped.
- R7: In a cycle with `cnt_valid_i` at 0, the value on `cnt_i` has no effect. Counts on either side of such an idle gap are treated as adjacent addresses.
- R8: A count accepted in the same cycle as `prof_end_i` counts as the last entry of the profile and is included in the results reported by that done.
- R9: With `CNT_W`=8 and `MAX_N_LOG2`=16, the results do not overflow. A profile of 65536 counts that are all 255 gives total 16711680 and peak `WIN`×255.
- R10: The same results hold for `WIN`=32 and for `WIN`=512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prof_start_i | input | 1 | Start of a profile; clears the accumulated state |
| cnt_valid_i | input | 1 | `cnt_i` holds the next address's count |
| cnt_i | input | CNT_W | Access count of the next address |
| prof_end_i | input | 1 | End of the profile; requests the results |
| done_o | output | 1 | One-cycle pulse when the results are updated |
| peak_o | output | CNT_W+MAX_N_LOG2 | Largest sum over `WIN` adjacent addresses |
| total_o | output | CNT_W+MAX_N_LOG2 | Sum of all accepted counts |

## Verification
The no-wrap assertions assume three things about the inputs. A profile holds at most 2^`MAX_N_LOG2` counts, start and end strobes never fall in the same cycle, and `WIN` is at least 2. The stimulus respects all three. Its longest profile holds exactly 65536 counts, and each profile opens with a start strobe in a cycle of its own. That start strobe sits at least one cycle after the previous end strobe. The bench runs one instance with a 32-entry window and one with a 512-entry window from the same stimulus. Both are compared every clock against a queue-based model.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
// swl_pkg: shared helpers for the locality meter.
// Assumes: callers pass positive integers.
package swl_pkg;

    // True when the argument is a power of two; selects the pointer wrap variant.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/swl_delay_line.sv
`timescale 1ns/1ps
// swl_delay_line: ring buffer that returns the count accepted WIN pushes ago.
// old_o is the entry that the current push overwrites. It is meaningful only
// while full_o is set. ready_o means the current push completes a full window.
// Assumes WIN >= 2. A clear restarts the fill level, so stale entries are
// never read.
module swl_delay_line
    import swl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WIN   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [CNT_W-1:0] din_i,
    output logic [CNT_W-1:0] old_o,
    output logic             full_o,
    output logic             ready_o
);
    localparam int PTR_W  = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int FILL_W = $clog2(WIN + 1);

    logic [CNT_W-1:0]  mem [WIN];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_inc;
    logic [FILL_W-1:0] fill_q;

    // Pointer advance: a natural wrap for powers of two, otherwise an explicit compare.
    generate
        if (is_pow2(WIN)) begin : g_pow2_wrap
            assign ptr_inc = ptr_q + PTR_W'(1);
        end else begin : g_cmp_wrap
            assign ptr_inc = (ptr_q == PTR_W'(WIN - 1)) ? '0 : ptr_q + PTR_W'(1);
        end
    endgenerate

    assign old_o   = mem[ptr_q];
    assign full_o  = (fill_q == FILL_W'(WIN));
    assign ready_o = (fill_q >= FILL_W'(WIN - 1));

    // Write pointer and fill level, restarted by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ptr_q  <= '0;
            fill_q <= '0;
        end else if (push_i) begin
            ptr_q <= ptr_inc;
            if (!full_o) fill_q <= fill_q + FILL_W'(1);
        end
    end

    // Storage of counts; no reset needed because the fill level guards reads.
    always_ff @(posedge clk) begin
        if (push_i && !clr_i) mem[ptr_q] <= din_i;
    end

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WIN)); // R3

endmodule

// File: rtl/swl_window_acc.sv
`timescale 1ns/1ps
// swl_window_acc: running window sum, grand total and peak window sum.
// Each push adds the new count. When the delay line is full, the push also
// subtracts the count that left the window. The peak is updated only on
// pushes that complete a full window. Next-state values go out so that the
// top can capture results that include the current push.
// Assumes no more than 2^(ACC_W-CNT_W) pushes between clears.
module swl_window_acc #(
    parameter int CNT_W = 8,
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [CNT_W-1:0] din_i,
    input  logic [CNT_W-1:0] old_i,
    input  logic             full_i,
    input  logic             ready_i,
    output logic [ACC_W-1:0] peak_nxt_o,
    output logic [ACC_W-1:0] total_nxt_o,
    output logic             win_nxt_o
);
    localparam int PAD_W = ACC_W - CNT_W;

    logic [ACC_W-1:0] sum_q, total_q, peak_q;
    logic             win_q;
    logic [ACC_W-1:0] sum_n, total_n, peak_n;
    logic             win_n;
    logic [ACC_W-1:0] din_x, old_x, slide_sum;

    assign din_x     = {{PAD_W{1'b0}}, din_i};
    assign old_x     = full_i ? {{PAD_W{1'b0}}, old_i} : '0;
    assign slide_sum = sum_q + din_x - old_x;

    // Next-state selection: clear, accept a count, or hold.
    always_comb begin
        sum_n   = sum_q;
        total_n = total_q;
        peak_n  = peak_q;
        win_n   = win_q;
        if (clr_i) begin
            sum_n   = '0;
            total_n = '0;
            peak_n  = '0;
            win_n   = 1'b0;
        end else if (push_i) begin
            sum_n   = slide_sum;
            total_n = total_q + din_x;
            win_n   = win_q | ready_i;
            if (ready_i && (slide_sum > peak_q)) peak_n = slide_sum;
        end
    end

    // Accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            total_q <= '0;
            peak_q  <= '0;
            win_q   <= 1'b0;
        end else begin
            sum_q   <= sum_n;
            total_q <= total_n;
            peak_q  <= peak_n;
            win_q   <= win_n;
        end
    end

    assign peak_nxt_o  = peak_n;
    assign total_nxt_o = total_n;
    assign win_nxt_o   = win_n;

    AST_SUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i && full_i) |-> ((sum_q + din_x) >= old_x)); // R3
    AST_TOTAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i) |-> (total_n >= total_q)); // R9
    AST_SUM_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= total_q); // R2
    AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (peak_q >= $past(peak_q))); // R3
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (total_q == '0 && peak_q == '0 && !win_q)); // R6

endmodule

// File: rtl/swl_locality_meter.sv
`timescale 1ns/1ps
// swl_locality_meter: finds the peak WIN-address window sum and the total of
// an access-count profile. When the end strobe arrives, the results, including
// any count accepted in that cycle, are captured and held, and done pulses one
// cycle later. A profile shorter than WIN reports its total as the peak.
// Assumes start and end strobes do not coincide, WIN >= 2 and at most
// 2^MAX_N_LOG2 counts per profile.
module swl_locality_meter #(
    parameter int CNT_W      = 8,
    parameter int WIN        = 32,
    parameter int MAX_N_LOG2 = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        prof_start_i,
    input  logic                        cnt_valid_i,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic                        prof_end_i,
    output logic                        done_o,
    output logic [CNT_W+MAX_N_LOG2-1:0] peak_o,
    output logic [CNT_W+MAX_N_LOG2-1:0] total_o
);
    localparam int ACC_W = CNT_W + MAX_N_LOG2;

    logic             push;
    logic [CNT_W-1:0] old_cnt;
    logic             dl_full, dl_ready;
    logic [ACC_W-1:0] peak_nxt, total_nxt;
    logic             win_nxt;
    logic             done_q;
    logic [ACC_W-1:0] peak_q, total_q;

    assign push = cnt_valid_i && !prof_start_i;

    swl_delay_line #(.CNT_W(CNT_W), .WIN(WIN)) u_dline (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (prof_start_i),
        .push_i  (push),
        .din_i   (cnt_i),
        .old_o   (old_cnt),
        .full_o  (dl_full),
        .ready_o (dl_ready)
    );

    swl_window_acc #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (prof_start_i),
        .push_i      (push),
        .din_i       (cnt_i),
        .old_i       (old_cnt),
        .full_i      (dl_full),
        .ready_i     (dl_ready),
        .peak_nxt_o  (peak_nxt),
        .total_nxt_o (total_nxt),
        .win_nxt_o   (win_nxt)
    );

    // Result capture at the end strobe; done follows one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            peak_q  <= '0;
            total_q <= '0;
        end else begin
            done_q <= prof_end_i;
            if (prof_end_i) begin
                total_q <= total_nxt;
                peak_q  <= win_nxt ? peak_nxt : total_nxt;
            end
        end
    end

    assign done_o  = done_q;
    assign peak_o  = peak_q;
    assign total_o = total_q;

    AST_PEAK_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (peak_o <= total_o)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !prof_end_i |=> ($stable(peak_o) && $stable(total_o))); // R5

endmodule

// File: tb/swl_locality_meter_tb_top.sv
`timescale 1ns/1ps
module swl_locality_meter_tb_top;
    localparam int CNT_W = 8;
    localparam int MAXL  = 16;
    localparam int ACC_W = CNT_W + MAXL;
    localparam int WA    = 32;
    localparam int WB    = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             st = 1'b0, vl = 1'b0, en = 1'b0;
    logic [CNT_W-1:0] cn = '0;
    logic             done_a, done_b;
    logic [ACC_W-1:0] peak_a, total_a, peak_b, total_b;

    int    errors = 0;
    int    checks = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    swl_locality_meter #(.CNT_W(CNT_W), .WIN(WA), .MAX_N_LOG2(MAXL)) dut_i (
        .clk(clk), .rst_n(rst_n), .prof_start_i(st), .cnt_valid_i(vl), .cnt_i(cn),
        .prof_end_i(en), .done_o(done_a), .peak_o(peak_a), .total_o(total_a));

    swl_locality_meter #(.CNT_W(CNT_W), .WIN(WB), .MAX_N_LOG2(MAXL)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .prof_start_i(st), .cnt_valid_i(vl), .cnt_i(cn),
        .prof_end_i(en), .done_o(done_b), .peak_o(peak_b), .total_o(total_b));

    // Behavioural reference: the profile as a queue, results computed on demand.
    int     prof[$];
    logic   exp_done = 1'b0;
    longint exp_pa = 0, exp_ta = 0, exp_pb = 0, exp_tb = 0;

    function automatic longint ref_total();
        longint t = 0;
        foreach (prof[i]) t += prof[i];
        return t;
    endfunction

    function automatic longint ref_peak(int w);
        longint s = 0, best = 0;
        if (prof.size() < w) return ref_total();
        for (int i = 0; i < prof.size(); i++) begin
            s += prof[i];
            if (i >= w) s -= prof[i-w];
            if (i >= w - 1 && s > best) best = s;
        end
        return best;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            prof.delete();
            exp_done <= 1'b0;
            exp_pa <= 0; exp_ta <= 0; exp_pb <= 0; exp_tb <= 0;
        end else begin
            if (st) prof.delete();
            else if (vl) prof.push_back(int'(cn));
            exp_done <= en;
            if (en) begin
                exp_pa <= ref_peak(WA);
                exp_pb <= ref_peak(WB);
                exp_ta <= ref_total();
                exp_tb <= ref_total();
            end
        end
    end

    task automatic check(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // Every-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check("done W32", longint'(done_a), longint'(exp_done));
            check("done W512", longint'(done_b), longint'(exp_done));
            check("peak W32", longint'(peak_a), exp_pa);
            check("total W32", longint'(total_a), exp_ta);
            check("peak W512", longint'(peak_b), exp_pb);
            check("total W512", longint'(total_b), exp_tb);
        end
    end

    task automatic drive(bit s, bit v, int c, bit e);
        @(negedge clk);
        st = s; vl = v; cn = CNT_W'(c); en = e;
    endtask

    function automatic int gen(int mode, int idx);
        case (mode)
            0: return int'($urandom_range(0, 255));
            1: return (idx >= 300 && idx < 812) ? int'($urandom_range(100, 255))
                                                : int'($urandom_range(0, 3));
            2: return 255;
            default: return (idx % 7 == 3) ? 200 : int'($urandom_range(0, 20));
        endcase
    endfunction

    // One profile: start strobe, n counts with optional idle gaps, end strobe.
    task automatic profile(int n, int mode, bit gaps, bit end_on_last);
        drive(1'b1, 1'b0, 0, 1'b0);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom_range(0, 3) == 0))
                drive(1'b0, 1'b0, int'($urandom_range(0, 255)), 1'b0); // R7 garbage
            drive(1'b0, 1'b1, gen(mode, i), end_on_last && (i == n - 1));
        end
        if (!end_on_last || n == 0) drive(1'b0, 1'b0, 0, 1'b1);
        drive(1'b0, 1'b0, 0, 1'b0);
        drive(1'b0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("reset done", longint'(done_a), 0);
        check("reset peak", longint'(peak_a), 0);
        check("reset total", longint'(total_b), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R4";  profile(10, 0, 1'b0, 1'b0);      // shorter than both windows
        cur_req = "R4";  profile(0, 0, 1'b0, 1'b0);       // empty profile
        cur_req = "R3";  profile(32, 0, 1'b0, 1'b0);      // exactly one window
        cur_req = "R8";  profile(45, 3, 1'b0, 1'b1);      // last count with end strobe
        cur_req = "R7";  profile(200, 0, 1'b1, 1'b0);     // idle gaps inside
        cur_req = "R2";  profile(150, 3, 1'b1, 1'b1);

        // R6: counts before a start are discarded; a count with start is dropped.
        cur_req = "R6";
        for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 250, 1'b0);
        drive(1'b1, 1'b1, 255, 1'b0);
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, i, 1'b0);
        drive(1'b0, 1'b0, 0, 1'b1);
        drive(1'b0, 1'b0, 0, 1'b0);

        // R5: back-to-back profiles, results held while idle.
        cur_req = "R5";
        profile(60, 0, 1'b0, 1'b1);
        repeat (10) drive(1'b0, 1'b0, 77, 1'b0);
        drive(1'b0, 1'b0, 0, 1'b1);                       // end without start: same profile
        drive(1'b0, 1'b0, 0, 1'b0);

        cur_req = "R10"; profile(1000, 1, 1'b1, 1'b0);    // hot region sized for W512
        cur_req = "R10"; profile(600, 0, 1'b0, 1'b1);
        cur_req = "R9";  profile(65536, 2, 1'b0, 1'b1);   // full-scale counts
        @(negedge clk);
        cur_req = "R9";
        check("full-scale total", longint'(total_a), 64'd16711680);
        check("full-scale peak W32", longint'(peak_a), 64'd8160);
        check("full-scale peak W512", longint'(peak_b), 64'd130560);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule